// File: doc/BRIEF.md
# Debounced Edge Event Counter

This block counts transitions of one polarity on a single external input and rejects contact bounce. The raw input is first brought into the clock domain through a short synchronizer chain. The first qualifying edge is counted straight away. The edge detector is then blanked for a programmable number of coarse timebase ticks, so that the chatter of a mechanical switch adds only one to the count.

Software configures the block with a single 16-bit write. The lower eight bits hold the blanking length N, measured in coarse ticks. Bit 8 picks the counted polarity. A write whose data is zero also clears the count. The tick timebase is a free-running prescaler, so the real blanking window is between N and N+1 ticks long. The count is read through a registered read port. A read captures the value held before any clear or increment that happens in the same cycle.

Top module: `bounce_event_counter`

## Requirements
- R1: The count is a 32-bit unsigned register. It increases by exactly one for each accepted edge.
- R2: The input passes through two synchronizer flops. A pin change driven before clock edge k produces its count increment at clock edge k+2. With rdEn held high, rdData shows the new count after edge k+3.
- R3: Configuration bit 8 selects the edge. A 0 counts falling edges (1 to 0) and a 1 counts rising edges (0 to 1). Edges of the other polarity never change the count.
- R4: After an accepted edge, the detector stays disarmed until the (N+1)th tick. N is taken from configuration bits 7:0 (0 to 255). A tick fires once every TICK_CYCLES clocks, so N = 0 still blanks until the next tick.
- R5: Edges of the selected polarity that arrive while the detector is disarmed are ignored.
- R6: A configuration write with data 0x0000 clears the count to zero. If an edge is accepted in the same cycle, the clear wins.
- R7: When rdEn is high at a clock edge, rdData takes the count held before that edge, even if the count is cleared or incremented at that same edge. When rdEn is low, rdData holds its value.
- R8: A nonzero configuration write loads N and the polarity and leaves the count unchanged.
- R9: After reset the count and rdData are zero, the detector is armed, N = 0, and falling edges are selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 1 | Asynchronous external input to be counted |
| cfgWr | input | 1 | Configuration write strobe |
| cfgData | input | 16 | Configuration word: [7:0] blanking ticks, [8] rising select; zero clears the count |
| rdEn | input | 1 | Read strobe; captures the count into rdData |
| rdData | output | 32 | Registered count read value |

## Verification
The bench drives bursts of bounce inside the blanking window and checks that a design which re-arms too early counts them. It places edges just before and just after the (N+1)th tick boundary, including N = 0, so an off-by-one in the blanking counter shows up as a count that is wrong by one. It applies a zero write together with a read and with a coincident edge. A design that returns the cleared value, or lets the increment beat the clear, is then exposed. Edges of the wrong polarity, and the exact synchronizer latency, are also checked against the bench's own cycle model.

// File: rtl/bounce_event_pkg.sv
package bounce_event_pkg;
  localparam int CFG_W   = 16;
  localparam int SPAN_W  = 8;
  localparam int COUNT_W = 32;

  typedef struct packed {
    logic incr;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/bounce_event_ctrl.sv
module bounce_event_ctrl
  import bounce_event_pkg::*;
#(
  parameter int TICK_CYCLES = 4_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinIn,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgData,
  output strobe_t          strb
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLvl;
  logic [PW-1:0]          preCnt;
  logic                   tick;
  logic [SPAN_W-1:0]      cfgSpan;
  logic                   cfgRise;
  logic                   armed;
  logic [SPAN_W-1:0]      blankLeft;
  logic                   curLvl, hit, accept;

  // synchronizer chain
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  assign curLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= curLvl;
  end

  // free-running coarse timebase
  assign tick = (preCnt == PW'(TICK_CYCLES - 1));
  always_ff @(posedge clk) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  // configuration register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgSpan <= '0;
      cfgRise <= 1'b0;
    end else if (cfgWr) begin
      cfgSpan <= cfgData[SPAN_W-1:0];
      cfgRise <= cfgData[SPAN_W];
    end
  end

  assign hit    = cfgRise ? (curLvl & ~prevLvl) : (~curLvl & prevLvl);
  assign accept = armed & hit;

  // blanking state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b1;
      blankLeft <= '0;
    end else if (accept) begin
      armed     <= 1'b0;
      blankLeft <= cfgSpan;
    end else if (!armed && tick) begin
      if (blankLeft == '0) armed <= 1'b1;
      else                 blankLeft <= blankLeft - 1'b1;
    end
  end

  always_comb begin
    strb       = '0;
    strb.incr  = accept;
    strb.clear = cfgWr && (cfgData == '0);
  end

  // R5: an accepted edge disarms, so no back-to-back increments
  p_single_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.incr |=> !strb.incr);
  // R4: blanking loads the configured span
  p_blank_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.incr |=> (!armed && blankLeft == $past(cfgSpan)));
  // R4: re-arming only happens on a tick
  p_rearm_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(tick));
endmodule

// File: rtl/bounce_event_dp.sv
module bounce_event_dp
  import bounce_event_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic               rdEn,
  output logic [COUNT_W-1:0] rdData
);
  logic [COUNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN)           count <= '0;
    else if (strb.clear) count <= '0;
    else if (strb.incr)  count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= count;
  end

  p_step_one_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incr && !strb.clear) |=> count == $past(count) + 1'b1);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.incr && !strb.clear) |=> $stable(count));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> count == '0);
  p_read_old_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdData == $past(count));
  p_read_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

// File: rtl/bounce_event_counter.sv
module bounce_event_counter
  import bounce_event_pkg::*;
#(
  parameter int TICK_CYCLES = 4_000_000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pinIn,
  input  logic                 cfgWr,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic                 rdEn,
  output logic [COUNT_W-1:0]   rdData
);
  strobe_t strb;

  bounce_event_ctrl #(.TICK_CYCLES(TICK_CYCLES), .SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .cfgWr(cfgWr), .cfgData(cfgData), .strb(strb)
  );

  bounce_event_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdEn(rdEn), .rdData(rdData)
  );
endmodule

// File: tb/bounce_event_counter_test.sv
`timescale 1ns/1ps
module bounce_event_counter_test;
  localparam int TICK = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinIn = 1'b0;
  logic        cfgWr = 1'b0;
  logic [15:0] cfgData = '0;
  logic        rdEn = 1'b1;
  logic [31:0] rdData;

  int  nRun = 0, nFail = 0;
  bit  finished = 0;
  string curReq = "R9";

  always #2 clk = ~clk;

  bounce_event_counter #(.TICK_CYCLES(TICK)) uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cfgWr(cfgWr),
    .cfgData(cfgData), .rdEn(rdEn), .rdData(rdData)
  );

  // behavioural reference
  int unsigned mCount, mRd;
  int  mPre, mLeft, mN;
  bit  mArmed, mRise;
  bit  hist[$];

  always @(posedge clk) begin
    bit tickNow, s2, pv, hit;
    if (!rstN) begin
      mCount = 0; mRd = 0; mPre = 0; mLeft = 0; mN = 0;
      mArmed = 1; mRise = 0; hist = '{0, 0, 0};
    end else begin
      tickNow = (mPre == TICK - 1);
      mPre = tickNow ? 0 : mPre + 1;
      s2 = hist[1]; pv = hist[2];
      hit = mRise ? (s2 && !pv) : (!s2 && pv);
      if (rdEn) mRd = mCount;
      if (mArmed && hit) begin
        mCount++; mArmed = 0; mLeft = mN;
      end else if (!mArmed && tickNow) begin
        if (mLeft == 0) mArmed = 1; else mLeft--;
      end
      if (cfgWr) begin
        if (cfgData == 0) mCount = 0;
        mN = cfgData[7:0]; mRise = cfgData[8];
      end
      hist.push_front(pinIn);
      void'(hist.pop_back());
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rstN && !finished) check(curReq, rdData, mRd);

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic wrCfg(logic [15:0] v);
    cfgData = v; cfgWr = 1'b1; cyc(1); cfgWr = 1'b0; cfgData = '0;
  endtask

  initial begin
    logic [31:0] v;
    cyc(4);
    rstN = 1'b1;
    cyc(1);
    check("R9", rdData, 32'd0);

    curReq = "R8"; pinIn = 1'b1; cyc(4);
    wrCfg(16'h0002); cyc(2);
    check("R8", rdData, 32'd0);

    // R2 latency: fall before edge k, rdData new after edge k+3
    curReq = "R2"; cyc(40);
    v = rdData; pinIn = 1'b0;
    repeat (3) @(posedge clk); @(negedge clk);
    check("R2", rdData, v);
    @(posedge clk); @(negedge clk);
    check("R2", rdData, v + 1);

    // R5: bounce within blanking
    curReq = "R5";
    for (int i = 0; i < 6; i++) begin pinIn = ~pinIn; cyc(2); end
    pinIn = 1'b1; cyc(3);
    check("R5", rdData, 32'd1);
    cyc(40);
    curReq = "R1"; pinIn = 1'b0; cyc(6);
    check("R1", rdData, 32'd2);

    // R3: rising edges, N = 0
    curReq = "R3"; pinIn = 1'b1; cyc(30);
    wrCfg(16'h0100); cyc(20);
    v = rdData;
    pinIn = 1'b0; cyc(20);
    check("R3", rdData, v);
    pinIn = 1'b1; cyc(20);
    check("R3", rdData, v + 1);

    // R4: sweep edge spacing around the tick boundary
    curReq = "R4";
    wrCfg(16'h0001);
    for (int gap = 3; gap < 3 * TICK; gap++) begin
      pinIn = 1'b1; cyc(gap); pinIn = 1'b0; cyc(gap);
    end
    wrCfg(16'h0100);
    for (int gap = 2; gap < 2 * TICK; gap++) begin
      pinIn = 1'b0; cyc(gap); pinIn = 1'b1; cyc(gap);
    end

    // R7 and R6: clear with simultaneous read
    curReq = "R7"; cyc(4);
    v = mCount;
    cfgData = 16'h0000; cfgWr = 1'b1; rdEn = 1'b1; cyc(1);
    cfgWr = 1'b0;
    check("R7", rdData, v);
    cyc(1);
    curReq = "R6";
    check("R6", rdData, 32'd0);

    // R6: clear coincides with an accepted falling edge
    pinIn = 1'b1; cyc(30);
    pinIn = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    cfgData = 16'h0000; cfgWr = 1'b1; cyc(1); cfgWr = 1'b0;
    cyc(2);
    check("R6", rdData, 32'd0);

    // R7: rdData holds when rdEn is low
    curReq = "R7"; cyc(30);
    pinIn = 1'b1; cyc(30); pinIn = 1'b0; cyc(6);
    v = rdData; rdEn = 1'b0;
    cyc(30); pinIn = 1'b1; cyc(30); pinIn = 1'b0; cyc(6);
    check("R7", rdData, v);
    rdEn = 1'b1; cyc(2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      nFail++; nRun++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule